// File: doc/BRIEF.md
# Multi-Bank Busy and Status Responder

This block sits beside a four-bank word-addressed flash array. It records which bank, if any, has an embedded program or erase operation running. For every read it decides whether the array's data may go straight out or whether a status word must be returned in its place. Reads to a bank that is not busy reach the array in the same cycle, with no wait, even while another bank is busy.

A read addressed to the busy bank returns a polling and toggle status word. Bit 7 is the data-polling bit. Bit 6 inverts on every status read while the operation runs. Bit 2 inverts only on reads of the sector selected for erase.

The duration of the embedded algorithm is modelled by a countdown loaded at start. An erase can be suspended and later resumed. A reset aborts the operation and returns every bank to array reads. Only one operation may run at a time. A start request made while busy is dropped and flagged.

Top module: `bank_status_responder`

## Requirements
- R1: Banks are decoded from the word address with Q = 2^(ADDR_W-3). Bank 0 covers [0,Q), bank 1 covers [Q,4Q), bank 2 covers [4Q,7Q) and bank 3 covers [7Q,8Q). After an accepted start, `bank_busy` equals 1 shifted left by the bank of `op_addr`.
- R2: A read (`rd_en`=1) to a bank whose `bank_busy` bit is 0 gives `rd_status`=0 in the same cycle.
- R3: A read to the busy bank while the operation is not suspended gives `rd_status`=1 in the same cycle. In `status_word`, bit 7 is the inverse of bit 7 of `op_data` for a program (`op_erase`=0) and 0 for an erase. Every bit other than 7, 6 and 2 is 0.
- R4: Bit 6 of the status word is 0 at start. It inverts after each clock edge at which `rd_status` was 1, except while suspended.
- R5: Bit 2 of the status word is 0 at start. During an erase it inverts after each status read whose address has the same sector number (address >> SECT_BITS) as `op_addr`. It does not change on other reads, and never changes during a program.
- R6: An accepted start keeps the bank busy for PROG_CYC (program) or ERASE_CYC (erase) clock edges after the start edge. `op_done` pulses high for one cycle as `bank_busy` clears, and reads to the bank then return array data.
- R7: `op_suspend` during a running erase freezes the countdown. While frozen, reads of other sectors in the bank give `rd_status`=0. Reads of the erased sector give status with bit 6 held and bit 2 still toggling. `op_suspend` during a program is ignored.
- R8: `op_resume` while suspended lets the countdown continue from where it stopped. The edge that takes the resume does not count.
- R9: `rst_n`=0 aborts any operation at once. It clears `bank_busy`, `rd_status`, `start_reject` and `op_done`.
- R10: `op_start` while a bank is busy is ignored. `start_reject` is 1 for exactly the cycle after that edge.
- R11: At most one bit of `bank_busy` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, aborts operations |
| rd_en | input | 1 | Read access this cycle |
| rd_addr | input | 22 | Read word address |
| op_start | input | 1 | Start program or erase |
| op_erase | input | 1 | 1 = erase, 0 = program |
| op_addr | input | 22 | Target word address of the operation |
| op_data | input | 16 | Data being programmed |
| op_suspend | input | 1 | Suspend a running erase |
| op_resume | input | 1 | Resume a suspended erase |
| rd_status | output | 1 | 1 = drive status word, 0 = drive array data |
| status_word | output | 16 | Polling and toggle status |
| bank_busy | output | 4 | One bit per bank with an operation in progress |
| start_reject | output | 1 | A start was dropped on the previous edge |
| op_done | output | 1 | Operation finished on the previous edge |

## Verification
The hardest situation to reach from the ports is a suspended erase. In that state the same bank gives array data for one sector and toggling status for another, and bit 6 is frozen while bit 2 keeps moving. The bench starts an erase in each bank in turn and suspends it part way through. It then alternates reads between the erased sector, a neighbouring sector of the same bank and the bank-boundary addresses of all four banks. A program is also started in each bank, with a suspend, and with a second start issued mid-operation, so the ignored-suspend and reject paths are covered under the same sweep.

// File: rtl/bank_status_responder.sv
module bank_status_responder #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int SECT_BITS = 15,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              op_start,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic              op_suspend,
  input  logic              op_resume,
  output logic              rd_status,
  output logic [DATA_W-1:0] status_word,
  output logic [3:0]        bank_busy,
  output logic              start_reject,
  output logic              op_done
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam int SW   = ADDR_W - SECT_BITS;

  function automatic logic [1:0] bank_of(input logic [ADDR_W-1:0] a);
    logic [2:0] t;
    t = a[ADDR_W-1 -: 3];
    if (t == 3'd0)      return 2'd0;
    else if (t <= 3'd3) return 2'd1;
    else if (t <= 3'd6) return 2'd2;
    else                return 2'd3;
  endfunction

  logic          busy_q, erase_q, susp_q, b7_q, t6_q, t2_q;
  logic [1:0]    bank_q;
  logic [SW-1:0] sect_q;
  logic [CW-1:0] cnt_q;
  logic          rd_hit, in_sect;

  assign in_sect   = rd_addr[ADDR_W-1:SECT_BITS] == sect_q;
  assign rd_hit    = busy_q && rd_en && (bank_of(rd_addr) == bank_q);
  assign rd_status = rd_hit && (!susp_q || in_sect);
  assign bank_busy = busy_q ? (4'b0001 << bank_q) : 4'b0000;

  always_comb begin
    status_word    = '0;
    status_word[7] = b7_q;
    status_word[6] = t6_q;
    status_word[2] = t2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; erase_q <= 1'b0; susp_q <= 1'b0;
      b7_q <= 1'b0; t6_q <= 1'b0; t2_q <= 1'b0;
      bank_q <= '0; sect_q <= '0; cnt_q <= '0;
      start_reject <= 1'b0; op_done <= 1'b0;
    end else begin
      start_reject <= op_start && busy_q;
      op_done      <= 1'b0;
      if (rd_status) begin
        if (!susp_q) t6_q <= ~t6_q;
        if (erase_q && in_sect) t2_q <= ~t2_q;
      end
      if (!busy_q) begin
        if (op_start) begin
          busy_q  <= 1'b1;
          erase_q <= op_erase;
          susp_q  <= 1'b0;
          bank_q  <= bank_of(op_addr);
          sect_q  <= op_addr[ADDR_W-1:SECT_BITS];
          b7_q    <= !op_erase && !op_data[7];
          t6_q    <= 1'b0;
          t2_q    <= 1'b0;
          cnt_q   <= op_erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
        end
      end else if (susp_q) begin
        if (op_resume) susp_q <= 1'b0;
      end else if (op_suspend && erase_q) begin
        susp_q <= 1'b1;
      end else if (cnt_q == '0) begin
        busy_q  <= 1'b0;
        op_done <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

module bank_status_responder_chk #(parameter int CW = 7) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_start,
  input logic          rd_status,
  input logic [3:0]    bank_busy,
  input logic          start_reject,
  input logic          op_done,
  input logic          susp,
  input logic [CW-1:0] cnt
);
  // R11
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_busy));
  // R10
  reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && (bank_busy != 4'b0)) |=> start_reject);
  // R10
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_reject |-> (bank_busy != 4'b0 || op_done));
  // R2
  status_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |-> (bank_busy != 4'b0));
  // R7
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp |=> $stable(cnt));
  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> (bank_busy == 4'b0));
endmodule

bind bank_status_responder bank_status_responder_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .rd_status(rd_status),
  .bank_busy(bank_busy), .start_reject(start_reject), .op_done(op_done),
  .susp(susp_q), .cnt(cnt_q)
);

// File: tb/bank_status_responder_bench.sv
module bank_status_responder_bench;
  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 40;
  localparam int Q   = 1 << 19;
  localparam int SEC = 1 << 15;

  logic clk = 0, rst_n = 0;
  logic rd_en = 0, op_start = 0, op_erase = 0, op_suspend = 0, op_resume = 0;
  logic [21:0] rd_addr = '0, op_addr = '0;
  logic [15:0] op_data = '0;
  logic rd_status, start_reject, op_done;
  logic [15:0] status_word;
  logic [3:0] bank_busy;

  always #2 clk = ~clk;

  bank_status_responder #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_bank_status_responder (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .op_start(op_start), .op_erase(op_erase), .op_addr(op_addr), .op_data(op_data),
    .op_suspend(op_suspend), .op_resume(op_resume), .rd_status(rd_status),
    .status_word(status_word), .bank_busy(bank_busy),
    .start_reject(start_reject), .op_done(op_done));

  int vectors = 0, fails = 0;
  bit m_busy, m_erase, m_susp, m_b7, m_t6, m_t2, m_resumed;
  int m_bank, m_sect, m_left;

  function automatic int bank_f(input int a);
    if (a < Q) return 0;
    else if (a < 4 * Q) return 1;
    else if (a < 7 * Q) return 2;
    else return 3;
  endfunction

  function automatic int base_f(input int b);
    case (b)
      0: return 0;
      1: return Q;
      2: return 4 * Q;
      default: return 7 * Q;
    endcase
  endfunction

  function automatic int probe_f(input int i);
    int e[8] = '{0, Q - 1, Q, 4 * Q - 1, 4 * Q, 7 * Q - 1, 7 * Q, 8 * Q - 1};
    return e[i];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic step(input bit rd, input int ra, input bit st, input bit er,
                      input int oa, input int od, input bit sp, input bit rs);
    bit sel, rej, done;
    int ew;
    @(negedge clk);
    rd_en = rd; rd_addr = 22'(ra); op_start = st; op_erase = er;
    op_addr = 22'(oa); op_data = 16'(od); op_suspend = sp; op_resume = rs;
    #1;
    sel = m_busy && rd && bank_f(ra) == m_bank && (!m_susp || (ra / SEC) == m_sect);
    chk(m_susp ? "R7 select" : (sel ? "R3 select" : "R2 select"), int'(rd_status), int'(sel));
    if (sel) begin
      ew = (int'(m_b7) << 7) | (int'(m_t6) << 6) | (int'(m_t2) << 2);
      chk("R3 polling bit", int'(status_word[7]), ew >> 7 & 1);
      chk(m_susp ? "R7 bit6 hold" : "R4 bit6", int'(status_word[6]), ew >> 6 & 1);
      chk("R5 bit2", int'(status_word[2]), ew >> 2 & 1);
      chk("R3 spare bits", int'(status_word & 16'hFFBB & 16'hFF7F), 0);
    end
    @(posedge clk);
    rej = st && m_busy;
    done = 0;
    if (sel) begin
      if (!m_susp) m_t6 = !m_t6;
      if (m_erase && (ra / SEC) == m_sect) m_t2 = !m_t2;
    end
    if (!m_busy) begin
      if (st) begin
        m_busy = 1; m_erase = er; m_susp = 0; m_resumed = 0;
        m_bank = bank_f(oa); m_sect = oa / SEC;
        m_b7 = !er && !od[7]; m_t6 = 0; m_t2 = 0;
        m_left = er ? ERASE_CYC : PROG_CYC;
      end
    end else if (m_susp) begin
      if (rs) begin m_susp = 0; m_resumed = 1; end
    end else if (sp && m_erase) m_susp = 1;
    else if (m_left == 1) begin m_busy = 0; done = 1; end
    else m_left--;
    #1;
    chk(m_resumed ? "R8 busy" : "R6 busy", int'(bank_busy), m_busy ? (1 << m_bank) : 0);
    chk("R11 one-hot", $countones(bank_busy) <= 1, 1);
    chk("R10 reject", int'(start_reject), int'(rej));
    chk(m_resumed ? "R8 done" : "R6 done", int'(op_done), int'(done));
    if (st && !rej) chk("R1 bank decode", int'(bank_busy), 1 << bank_f(oa));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 0; rd_en = 1; op_start = 0; op_suspend = 0; op_resume = 0;
    #1;
    chk("R9 busy clear", int'(bank_busy), 0);
    chk("R9 select clear", int'(rd_status), 0);
    chk("R9 flags clear", int'({start_reject, op_done}), 0);
    m_busy = 0; m_susp = 0; m_resumed = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    m_busy = 0; m_susp = 0; m_resumed = 0;
    apply_reset();
    for (int i = 0; i < 8; i++) step(1, probe_f(i), 0, 0, 0, 0, 0, 0);
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 2; k++) begin
        int tgt, od, n;
        tgt = base_f(b) + (b + 1) * SEC + 3;
        od  = ((b + k) % 2 == 1) ? 16'h0080 : 16'h1234;
        step(1, tgt, 1, k[0], tgt, od, 0, 0);
        n = 0;
        while (m_busy && n < 200) begin
          int ra;
          case (n % 10)
            8: ra = tgt;
            9: ra = tgt + SEC;
            default: ra = (n % 10 < 8) ? probe_f(n % 10) : tgt;
          endcase
          if (n % 3 == 1) ra = tgt;
          step(n % 7 != 6, ra, n == 3, 0, base_f((b + 1) % 4), 0, n == 5, n == 14);
          n++;
        end
        step(1, tgt, 0, 0, 0, 0, 0, 0);
      end
    end
    begin
      int tgt;
      tgt = base_f(2) + 2 * SEC;
      step(1, tgt, 1, 1, tgt, 0, 0, 0);
      step(1, tgt, 0, 0, 0, 0, 1, 0);
      step(1, tgt + SEC, 0, 0, 0, 0, 0, 0);
      step(1, tgt, 0, 0, 0, 0, 0, 0);
      apply_reset();
      step(1, tgt, 0, 0, 0, 0, 0, 0);
      step(1, tgt, 1, 0, tgt, 16'h0000, 0, 0);
      step(1, tgt, 0, 0, 0, 0, 0, 0);
    end
    summary();
  end
endmodule